// File: doc/BRIEF.md
# Flash Read-While-Write Arbitration Controller

This block sits between a bus read port and a flash array. It decides what happens to a read that arrives while the array is running a program or erase operation. The array signals that it is busy by holding its done output low. The controller itself keeps no record of the operation.

A 3-bit policy input selects the response to such a read. When the top bit of the policy is 0, the read is refused with a two-cycle bus error and never reaches the array. When the top bit is 1, the controller holds bus ready low and keeps the request address and attributes in holding registers. Once the array is idle again, it replays the read from those registers. Values 0b100 to 0b110 are reserved stall variants and behave like 0b111, which is the basic stall mode. The register that feeds this input is expected to reset to 0b111.

The same decision applies when the array turns busy while a read is already in flight, which shows as a falling edge on done. In stall mode the interrupted read is dropped and replayed later. In error mode it ends with the bus error. A read issued to an idle array completes normally: ready goes high for one cycle with the array data.

Top module: `flash_rww_ctrl`

## Requirements
- R1: After reset, bus_ready is 1, bus_err is 0 and arr_req is 0.
- R2: A read accepted (bus_req high while bus_ready is high) with array_done at 1 is issued to the array exactly once. Bus ready stays low for two cycles, and the response carries the array data that was returned with arr_ack.
- R3: The array counts as busy whenever array_done is 0. With policy[2] = 0, a read accepted while busy gets an error sequence: one cycle with bus_ready 0 and bus_err 1, then one cycle with bus_ready 1 and bus_err 1.
- R4: A read refused with an error is never forwarded to the array. arr_req stays 0 for that request.
- R5: Every policy value from 0b000 to 0b011 selects the error response. Every value from 0b100 to 0b111 selects the stall response.
- R6: In stall mode, a read accepted while busy holds bus_ready low until array_done returns to 1. The read is then issued once. If done returns before the K-th clock edge after acceptance, ready is low for K+2 cycles.
- R7: The replayed read carries the address and attributes captured at acceptance. Bus address and attribute changes during the stall have no effect.
- R8: A falling edge on array_done while the issued read is waiting for arr_ack aborts that read, and this takes priority over an arr_ack in the same cycle. Stall mode then stalls and reissues the read once the array is idle. Error mode ends the read with the error sequence of R3.
- R9: A successful response holds bus_ready high with bus_err 0 for one cycle. With no new request, the controller then returns to idle with bus_ready 1 and bus_err 0.
- R10: arr_req is never 1 while array_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 3 | Read-while-busy policy; top bit 0 selects error, 1 selects stall |
| bus_req | input | 1 | Read request from the bus, taken when bus_ready is high |
| bus_addr | input | AW | Read address |
| bus_attr | input | TW | Transfer attributes |
| bus_ready | output | 1 | Bus ready; low while a read is pending |
| bus_err | output | 1 | Bus error response |
| bus_rdata | output | DW | Read data, valid with a ready cycle that has no error |
| array_done | input | 1 | Array done; 0 while a program or erase runs |
| arr_req | output | 1 | One-cycle read strobe to the array |
| arr_addr | output | AW | Address presented to the array |
| arr_attr | output | TW | Attributes presented to the array |
| arr_ack | input | 1 | Array read data valid |
| arr_rdata | input | DW | Array read data |

## Verification
The read path is tried under three array patterns: idle at acceptance, busy at acceptance for varying durations, and turning busy one cycle after the read is issued. Each pattern is run under all eight policy values. The idle pattern sets the baseline latency and data path. The busy pattern separates the error from the stall response and checks that the ready-low length grows exactly with the busy time. The in-flight pattern shows that the aborted result is discarded and the read is reissued, with the reissue count telling a single issue from a replay. During stalls the bus address is overwritten, so a replay that read the live bus instead of the captured request shows up as a wrong address and wrong data.

// File: rtl/flash_rww_pkg.sv
package flash_rww_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_STALL = 3'd3,
    ST_ERR1  = 3'd4,
    ST_ERR2  = 3'd5,
    ST_RESP  = 3'd6
  } rww_state_t;

  // Top policy bit clear means refuse with an error.
  function automatic logic policy_errors(input logic [2:0] pol);
    return ~pol[2];
  endfunction

  // Where a read goes when it meets a busy array.
  function automatic rww_state_t blocked_next(input logic [2:0] pol);
    return policy_errors(pol) ? ST_ERR1 : ST_STALL;
  endfunction

  // Where a freshly accepted read goes.
  function automatic rww_state_t accept_next(input logic busy, input logic [2:0] pol);
    return busy ? blocked_next(pol) : ST_ISSUE;
  endfunction

  // Number of bus cycles with ready low for a read in a given situation.
  function automatic int unsigned ready_low_cycles(input logic [2:0] pol,
                                                   input logic busy_at_accept,
                                                   input logic fall_in_flight,
                                                   input int unsigned busy_len);
    if (busy_at_accept)
      return policy_errors(pol) ? 1 : busy_len + 2;
    if (fall_in_flight)
      return policy_errors(pol) ? 3 : busy_len + 4;
    return 2;
  endfunction

endpackage

// File: rtl/flash_rww_busy_mon.sv
module flash_rww_busy_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic done_in,
  output logic busy,
  output logic fall
);
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b1;
    else        done_q <= done_in;
  end

  assign busy = ~done_in;
  assign fall = done_q & ~done_in;

endmodule

// File: rtl/flash_rww_capture.sv
module flash_rww_capture #(
  parameter int AW = 8,
  parameter int TW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_en,
  input  logic [AW-1:0] req_addr,
  input  logic [TW-1:0] req_attr,
  input  logic          dat_en,
  input  logic [DW-1:0] dat_in,
  output logic [AW-1:0] held_addr,
  output logic [TW-1:0] held_attr,
  output logic [DW-1:0] held_dat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr <= '0;
      held_attr <= '0;
    end else if (req_en) begin
      held_addr <= req_addr;
      held_attr <= req_attr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_dat <= '0;
    else if (dat_en) held_dat <= dat_in;
  end

endmodule

// File: rtl/flash_rww_fsm.sv
module flash_rww_fsm
  import flash_rww_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] policy,
  input  logic       bus_req,
  input  logic       busy,
  input  logic       fall,
  input  logic       arr_ack,
  output logic       bus_ready,
  output logic       bus_err,
  output logic       arr_req,
  output logic       accept,
  output logic       dat_load,
  output logic       stall_w,
  output logic       wait_w,
  output logic       rsp_w
);
  rww_state_t state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    bus_ready = 1'b0;
    bus_err   = 1'b0;
    arr_req   = 1'b0;
    unique case (state)
      ST_IDLE:  bus_ready = 1'b1;
      ST_ISSUE: arr_req   = ~busy;
      ST_ERR1:  bus_err   = 1'b1;
      ST_ERR2:  begin bus_ready = 1'b1; bus_err = 1'b1; end
      ST_RESP:  bus_ready = 1'b1;
      default:  ;
    endcase
  end

  assign accept   = bus_req & bus_ready;
  assign stall_w  = (state == ST_STALL);
  assign wait_w   = (state == ST_WAIT);
  assign rsp_w    = (state == ST_RESP);
  assign dat_load = wait_w & arr_ack & ~fall;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_RESP, ST_ERR2:
        nxt = accept ? accept_next(busy, policy) : ST_IDLE;
      ST_ISSUE: nxt = busy ? blocked_next(policy) : ST_WAIT;
      ST_WAIT:  nxt = fall ? blocked_next(policy) : (arr_ack ? ST_RESP : ST_WAIT);
      ST_STALL: nxt = busy ? ST_STALL : ST_ISSUE;
      ST_ERR1:  nxt = ST_ERR2;
      default:  nxt = ST_IDLE;
    endcase
  end

  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_ready) |=> (bus_err && bus_ready)); // R3
  AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !arr_req); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |-> !bus_ready); // R6
  AST_RESP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_w |-> $past(arr_ack)); // R2
  AST_FALL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_w && fall && policy[2]) |=> stall_w); // R8
  AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_w && !bus_req) |=> (!rsp_w && bus_ready && !bus_err)); // R9

endmodule

// File: rtl/flash_rww_ctrl.sv
module flash_rww_ctrl #(
  parameter int AW = 8,
  parameter int TW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    policy,
  input  logic          bus_req,
  input  logic [AW-1:0] bus_addr,
  input  logic [TW-1:0] bus_attr,
  output logic          bus_ready,
  output logic          bus_err,
  output logic [DW-1:0] bus_rdata,
  input  logic          array_done,
  output logic          arr_req,
  output logic [AW-1:0] arr_addr,
  output logic [TW-1:0] arr_attr,
  input  logic          arr_ack,
  input  logic [DW-1:0] arr_rdata
);
  logic busy_w, fall_w, accept_w, dat_load_w;
  logic stall_w, wait_w, rsp_w;

  flash_rww_busy_mon u_busy (
    .clk(clk), .rst_n(rst_n), .done_in(array_done),
    .busy(busy_w), .fall(fall_w)
  );

  flash_rww_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .policy(policy), .bus_req(bus_req),
    .busy(busy_w), .fall(fall_w), .arr_ack(arr_ack),
    .bus_ready(bus_ready), .bus_err(bus_err), .arr_req(arr_req),
    .accept(accept_w), .dat_load(dat_load_w),
    .stall_w(stall_w), .wait_w(wait_w), .rsp_w(rsp_w)
  );

  flash_rww_capture #(.AW(AW), .TW(TW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .req_en(accept_w), .req_addr(bus_addr), .req_attr(bus_attr),
    .dat_en(dat_load_w), .dat_in(arr_rdata),
    .held_addr(arr_addr), .held_attr(arr_attr), .held_dat(bus_rdata)
  );

  AST_BUSY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !array_done |-> !arr_req); // R10
  AST_CAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> ($stable(arr_addr) && $stable(arr_attr))); // R7

endmodule

// File: tb/test_flash_rww_ctrl.sv
module test_flash_rww_ctrl;
  localparam int AW = 8;
  localparam int TW = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] policy = 3'b111;
  logic bus_req = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [TW-1:0] bus_attr = '0;
  logic bus_ready, bus_err;
  logic [DW-1:0] bus_rdata;
  logic array_done = 1'b1;
  logic arr_req;
  logic [AW-1:0] arr_addr;
  logic [TW-1:0] arr_attr;
  logic arr_ack = 1'b0;
  logic [DW-1:0] arr_rdata = '0;

  int total = 0;
  int bad = 0;
  int issues = 0;
  int issue_mismatch = 0;
  int busy_issue = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [TW-1:0] exp_attr = '0;

  always #5 clk = ~clk;

  flash_rww_ctrl #(.AW(AW), .TW(TW), .DW(DW)) i_flash_rww_ctrl (
    .clk(clk), .rst_n(rst_n), .policy(policy), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .array_done(array_done),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_attr(arr_attr),
    .arr_ack(arr_ack), .arr_rdata(arr_rdata)
  );

  function automatic logic [DW-1:0] array_word(input logic [AW-1:0] a);
    return {a ^ 8'hA5, ~a};
  endfunction

  // Array model: one-cycle read latency, data is a function of the address.
  always @(posedge clk) begin
    arr_ack <= arr_req;
    arr_rdata <= array_word(arr_addr);
    if (arr_req) begin
      issues <= issues + 1;
      if (arr_addr != exp_addr || arr_attr != exp_attr) issue_mismatch <= issue_mismatch + 1;
      if (!array_done) busy_issue <= busy_issue + 1;
    end
  end

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: idle array, 1: busy at acceptance, 2: busy edge after issue
  task automatic run(input logic [2:0] pol, input logic [AW-1:0] a,
                     input logic [TW-1:0] t, input int mode, input int k);
    int lows = 0;
    int exp_lows, exp_issues;
    logic errm = ~pol[2];
    logic saw_err_low = 1'b0;
    bit done_flag = 0;
    @(negedge clk);
    policy = pol;
    exp_addr = a;
    exp_attr = t;
    issues = 0;
    issue_mismatch = 0;
    if (mode == 1) array_done = 1'b0;
    bus_req = 1'b1; bus_addr = a; bus_attr = t;
    for (int i = 1; i < 200 && !done_flag; i++) begin
      @(negedge clk);
      bus_req = 1'b0; bus_addr = ~a; bus_attr = ~t;
      if (bus_ready) done_flag = 1;
      else begin
        lows++;
        if (bus_err) saw_err_low = 1'b1;
        if (mode == 1 && i == k) array_done = 1'b1;
        if (mode == 2 && i == 2) array_done = 1'b0;
        if (mode == 2 && i == 2 + k) array_done = 1'b1;
      end
    end
    if (mode == 1) exp_lows = errm ? 1 : k + 2;
    else if (mode == 2) exp_lows = errm ? 3 : k + 4;
    else exp_lows = 2;
    if (mode == 0) exp_issues = 1;
    else if (mode == 1) exp_issues = errm ? 0 : 1;
    else exp_issues = errm ? 1 : 2;
    check("R6 ready-low length", lows == exp_lows, lows, exp_lows);
    if (mode != 0 && errm) begin
      check("R3 error on final cycle", bus_err == 1'b1, bus_err, 1);
      check("R3 error on first cycle", saw_err_low, saw_err_low, 1);
      check("R5 error policy", 1'b1, pol, pol);
    end else begin
      check("R2 no error", bus_err == 1'b0, bus_err, 0);
      check("R2 data", bus_rdata == array_word(a), bus_rdata, array_word(a));
    end
    if (mode == 1 && errm)
      check("R4 no issue", issues == 0, issues, 0);
    else if (mode == 2)
      check("R8 issue count", issues == exp_issues, issues, exp_issues);
    else
      check("R2 issue count", issues == exp_issues, issues, exp_issues);
    check("R7 replay address/attr", issue_mismatch == 0, issue_mismatch, 0);
    array_done = 1'b1;
    @(negedge clk);
    check("R9 back to idle", bus_ready && !bus_err, {bus_ready, bus_err}, 2'b10);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready at reset", bus_ready == 1'b1, bus_ready, 1);
    check("R1 err at reset", bus_err == 1'b0, bus_err, 0);
    check("R1 arr_req at reset", arr_req == 1'b0, arr_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 3; m++) begin
        for (int k = 1; k <= 4; k++) begin
          run(3'(p), 8'(p * 37 + m * 11 + k), 4'(p + k), m, k);
        end
      end
    end
    check("R10 no issue while busy", busy_issue == 0, busy_issue, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule